// File: doc/BRIEF.md
# Pointer-Indexed Serial Console Port

This block is a small serial console port on a byte-wide register bus. It has two registers, a control/status register and a data register. A byte written to the data register goes out at once on the transmit output, and the block flags the transmit side as pending and raises its interrupt. Bytes that arrive on a valid/ready stream are held in a small receive queue. Each data-register read takes the oldest of them.

The status register is read indirectly. Any write to the control register loads a register pointer. The next status read is interpreted through that pointer. Pointer value 3 selects the interrupt-pending view and snaps the pointer back to 0 once it has been used. Every other pointer value gives the ordinary status view. Software clears the transmit interrupt by writing an acknowledge command to the control register. Misuse sets a sticky error output: an acknowledge with nothing to acknowledge, or a data read from an empty queue. Reads return their data one cycle after the strobe, marked by a valid pulse.

Top module: `ser_ptr_port`

## Requirements
- R1: A synchronous active-high reset clears the pointer, both pending flags and the error flag. After reset `irq`, `err`, `tx_valid` and `rd_valid` are 0 and `rx_ready` is 1.
- R2: The control register sits at address 0x80 and the data register at 0xC0. A read of any other address returns 0x00, and a write to any other address changes nothing. When `bus_rd` and `bus_wr` are both high, only the read takes place.
- R3: Any write to the control register loads the written byte into the pointer. A status read while the pointer is 3 returns the pending view and resets the pointer to 0. The pending view is 0x10 if transmit is pending, otherwise 0x20 if receive is pending, otherwise 0x00.
- R4: A status read with any pointer other than 3 returns 0x04 (bit 2, transmitter empty), with bit 0 also set when receive is pending. The pointer is left unchanged.
- R5: A write to the data register drives the byte on `tx_data` with a one-cycle `tx_valid` pulse in the next cycle. It sets transmit-pending, and `irq` is high from that cycle on.
- R6: Writing 0x28 to the control register clears transmit-pending. `irq` then falls unless receive is pending. If transmit was not pending, the error flag is set.
- R7: A byte is accepted when `rx_valid` and `rx_ready` are both high. Receive-pending and `irq` are set in the next cycle. The queue holds DEPTH bytes, and `rx_ready` is low while it is full.
- R8: Data reads return received bytes in arrival order. Receive-pending clears when a read leaves the queue empty. A byte arriving in the same cycle as that read keeps receive-pending set.
- R9: A data read from an empty queue returns 0x00 and sets the error flag. A byte that arrives in the same cycle is not visible to that read, but it is queued.
- R10: The error flag, output on `err`, stays set until reset.
- R11: `rd_valid` is high exactly in the cycle after each `bus_rd`, and `rd_data` holds the result during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Receive queue can accept a byte |
| tx_data | output | 8 | Transmitted byte |
| tx_valid | output | 1 | Transmit strobe, one cycle |
| irq | output | 1 | Interrupt, high while any pending flag is set |
| err | output | 1 | Sticky protocol-error flag |

## Verification
Two functions can fall in the same cycle: a data read popping the receive queue and a byte arriving on the stream. The bench provokes this twice. The first time the queue is empty, so the read must return 0x00 and raise `err` while the new byte is still queued. The second time the queue holds one byte, so the read must return that byte and `irq` must stay high because of the arrival. Both cases are judged against the bench's queue model on every clock. Direct literal checks of the read data and interrupt back them up. A random phase that drives `rx_valid` alongside bus traffic then exercises the same overlap repeatedly.

// File: rtl/ser_ptr_pkg.sv
package ser_ptr_pkg;
  localparam int BYTE_W = 8;

  // pointer value that selects the pending view for one status read
  localparam logic [BYTE_W-1:0] PTR_PEND_SEL = 8'h03;
  // control command that retires the transmit interrupt
  localparam logic [BYTE_W-1:0] CMD_TX_ACK   = 8'h28;

  // bit positions in the two status views
  localparam int ST_RX_AVAIL = 0;
  localparam int ST_TX_EMPTY = 2;
  localparam int PV_TX       = 4;
  localparam int PV_RX       = 5;

  typedef struct packed {
    logic ctrl_wr;
    logic ctrl_rd;
    logic data_wr;
    logic data_rd;
    logic any_rd;
  } bus_op_t;
endpackage

// File: rtl/ser_ptr_decode.sv
module ser_ptr_decode
  import ser_ptr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8'h80),
  parameter logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(8'hC0)
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output bus_op_t           op
);
  logic hit_ctrl;
  logic hit_data;
  logic wr_eff;

  assign hit_ctrl = (bus_addr == CTRL_OFS);
  assign hit_data = (bus_addr == DATA_OFS);
  // a read in the same cycle takes the bus; the write is dropped
  assign wr_eff   = bus_wr & ~bus_rd;

  always_comb begin
    op.ctrl_wr = wr_eff & hit_ctrl;
    op.data_wr = wr_eff & hit_data;
    op.ctrl_rd = bus_rd & hit_ctrl;
    op.data_rd = bus_rd & hit_data;
    op.any_rd  = bus_rd;
  end
endmodule

// File: rtl/ser_ptr_rxq.sv
module ser_ptr_rxq #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                     full,
  output logic                     empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp;
  logic [PTR_W-1:0] rp;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + PTR_W'(1);
      if (pop)  rp <= (rp == LAST) ? '0 : rp + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = mem[rp];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/ser_ptr_core.sv
module ser_ptr_core
  import ser_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_op_t           op,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] q_head,
  input  logic              q_empty,
  input  logic              q_last,
  input  logic              q_push,
  output logic              q_pop,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              irq,
  output logic              err,
  output logic              tx_pend,
  output logic              rx_pend
);
  logic [BYTE_W-1:0] ptr_q;
  logic [BYTE_W-1:0] ptr_n;
  logic              tx_pend_n;
  logic              rx_pend_n;
  logic              err_n;
  logic              ack_cmd;
  logic [BYTE_W-1:0] status_v;
  logic [BYTE_W-1:0] rdata_n;

  assign ack_cmd = op.ctrl_wr && (wdata == CMD_TX_ACK);
  assign q_pop   = op.data_rd & ~q_empty;

  // status value seen through the current pointer
  always_comb begin
    status_v = '0;
    if (ptr_q == PTR_PEND_SEL) begin
      if (tx_pend)      status_v[PV_TX] = 1'b1;
      else if (rx_pend) status_v[PV_RX] = 1'b1;
    end else begin
      status_v[ST_TX_EMPTY] = 1'b1;
      status_v[ST_RX_AVAIL] = rx_pend;
    end
  end

  always_comb begin
    rdata_n = '0;
    if (op.ctrl_rd)                  rdata_n = status_v;
    else if (op.data_rd && !q_empty) rdata_n = q_head;
  end

  always_comb begin
    ptr_n = ptr_q;
    if (op.ctrl_wr)                                ptr_n = wdata;
    else if (op.ctrl_rd && ptr_q == PTR_PEND_SEL)  ptr_n = '0;

    tx_pend_n = tx_pend;
    if (op.data_wr)    tx_pend_n = 1'b1;
    else if (ack_cmd)  tx_pend_n = 1'b0;

    rx_pend_n = rx_pend;
    if (q_push)               rx_pend_n = 1'b1;
    else if (q_pop && q_last) rx_pend_n = 1'b0;

    err_n = err | (ack_cmd & ~tx_pend) | (op.data_rd & q_empty);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      tx_pend  <= 1'b0;
      rx_pend  <= 1'b0;
      err      <= 1'b0;
      irq      <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      ptr_q    <= ptr_n;
      tx_pend  <= tx_pend_n;
      rx_pend  <= rx_pend_n;
      err      <= err_n;
      irq      <= tx_pend_n | rx_pend_n;
      rd_valid <= op.any_rd;
      if (op.any_rd)  rd_data <= rdata_n;
      tx_valid <= op.data_wr;
      if (op.data_wr) tx_data <= wdata;
    end
  end
endmodule

// File: rtl/ser_ptr_port.sv
module ser_ptr_port
  import ser_ptr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8'h80),
  parameter logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(8'hC0),
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              irq,
  output logic              err
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  bus_op_t           op;
  logic              q_push;
  logic              q_pop;
  logic [BYTE_W-1:0] q_head;
  logic [CNT_W-1:0]  rxq_count;
  logic              q_full;
  logic              q_empty;
  logic              tx_pend;
  logic              rx_pend;

  ser_ptr_decode #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .DATA_OFS(DATA_OFS)
  ) u_dec (
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .op      (op)
  );

  assign rx_ready = ~q_full;
  assign q_push   = rx_valid & ~q_full;

  ser_ptr_rxq #(
    .DEPTH(DEPTH),
    .W    (BYTE_W)
  ) u_rxq (
    .clk  (clk),
    .rst  (rst),
    .push (q_push),
    .din  (rx_data),
    .pop  (q_pop),
    .head (q_head),
    .count(rxq_count),
    .full (q_full),
    .empty(q_empty)
  );

  ser_ptr_core u_core (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .wdata   (bus_wdata),
    .q_head  (q_head),
    .q_empty (q_empty),
    .q_last  (rxq_count == CNT_W'(1)),
    .q_push  (q_push),
    .q_pop   (q_pop),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .tx_data (tx_data),
    .tx_valid(tx_valid),
    .irq     (irq),
    .err     (err),
    .tx_pend (tx_pend),
    .rx_pend (rx_pend)
  );
endmodule

// File: rtl/ser_ptr_chk.sv
module ser_ptr_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8'h80),
  parameter logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(8'hC0),
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic              rd_valid,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_valid,
  input logic              irq,
  input logic              err,
  input logic              tx_pend,
  input logic              rx_pend,
  input logic [CNT_W-1:0]  rxq_count
);
  assert_tx_send_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == DATA_OFS)
      |=> (tx_valid && irq && tx_data == $past(bus_wdata)));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == CTRL_OFS && bus_wdata == 8'h28) |=> !tx_pend);

  assert_rx_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready) |=> (irq && rxq_count != '0));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    rxq_count <= CNT_W'(DEPTH));

  assert_rx_pend_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    rx_pend == (rxq_count != '0));

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (rst)
    irq == (tx_pend || rx_pend));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);

  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !rd_valid);
endmodule

bind ser_ptr_port ser_ptr_chk #(
  .ADDR_W  (ADDR_W),
  .CTRL_OFS(CTRL_OFS),
  .DATA_OFS(DATA_OFS),
  .DEPTH   (DEPTH),
  .CNT_W   (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .rd_valid (rd_valid),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .tx_data  (tx_data),
  .tx_valid (tx_valid),
  .irq      (irq),
  .err      (err),
  .tx_pend  (tx_pend),
  .rx_pend  (rx_pend),
  .rxq_count(rxq_count)
);

// File: tb/tb_ser_ptr_port.sv
`timescale 1ns/1ps
module tb_ser_ptr_port;
  localparam int DEPTH = 16;
  localparam logic [7:0] A_CTRL = 8'h80;
  localparam logic [7:0] A_DATA = 8'hC0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       irq;
  logic       err;

  always #10 clk = ~clk;

  ser_ptr_port #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq), .err(err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  int         m_ptr;
  bit         m_txp, m_err, m_rv, m_txv, m_irq;
  logic [7:0] m_rdata, m_txd;
  logic [7:0] q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(input bit r, input bit rd, input bit wr, input logic [7:0] a,
                            input logic [7:0] wd, input bit rv, input logic [7:0] rb);
    bit acc;
    bit w;
    if (r) begin
      m_ptr = 0; m_txp = 0; m_err = 0; m_rv = 0; m_txv = 0; m_irq = 0;
      m_rdata = 8'h00; m_txd = 8'h00; q.delete();
      return;
    end
    acc = rv && (q.size() < DEPTH);
    w = wr && !rd;
    m_rv = rd;
    m_txv = 0;
    if (rd) begin
      if (a == A_CTRL) begin
        if (m_ptr == 3) begin
          m_rdata = m_txp ? 8'h10 : (q.size() > 0 ? 8'h20 : 8'h00);
          m_ptr = 0;
        end else begin
          m_rdata = (q.size() > 0) ? 8'h05 : 8'h04;
        end
      end else if (a == A_DATA) begin
        if (q.size() > 0) m_rdata = q.pop_front();
        else begin m_rdata = 8'h00; m_err = 1; end
      end else m_rdata = 8'h00;
    end
    if (w && a == A_CTRL) begin
      if (wd == 8'h28) begin
        if (!m_txp) m_err = 1;
        m_txp = 0;
      end
      m_ptr = int'(wd);
    end else if (w && a == A_DATA) begin
      m_txv = 1; m_txd = wd; m_txp = 1;
    end
    if (acc) q.push_back(rb);
    m_irq = m_txp || (q.size() > 0);
  endtask

  task automatic compare(input string tag);
    chk(rd_valid == m_rv, tag, "rd_valid", rd_valid, m_rv);
    if (m_rv) chk(rd_data == m_rdata, tag, "rd_data", rd_data, m_rdata);
    chk(tx_valid == m_txv, tag, "tx_valid", tx_valid, m_txv);
    if (m_txv) chk(tx_data == m_txd, tag, "tx_data", tx_data, m_txd);
    chk(irq == m_irq, tag, "irq", irq, m_irq);
    chk(err == m_err, tag, "err", err, m_err);
    chk(rx_ready == (q.size() < DEPTH), tag, "rx_ready", rx_ready, q.size() < DEPTH);
  endtask

  // drive at the falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input bit r, input bit rd, input bit wr, input logic [7:0] a,
                      input logic [7:0] wd, input bit rv, input logic [7:0] rb,
                      input string tag);
    rst = r; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_data = rb;
    @(posedge clk);
    model_edge(r, rd, wr, a, wd, rv, rb);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    step(1, 0, 0, 8'h00, 8'h00, 0, 8'h00, tag);
    step(1, 0, 0, 8'h00, 8'h00, 0, 8'h00, tag);
  endtask
  task automatic idle(input string tag);            step(0, 0, 0, 8'h00, 8'h00, 0, 8'h00, tag); endtask
  task automatic wr_ctrl(input logic [7:0] v, input string tag); step(0, 0, 1, A_CTRL, v, 0, 8'h00, tag); endtask
  task automatic wr_data(input logic [7:0] v, input string tag); step(0, 0, 1, A_DATA, v, 0, 8'h00, tag); endtask
  task automatic rd_ctrl(input string tag);         step(0, 1, 0, A_CTRL, 8'h00, 0, 8'h00, tag); endtask
  task automatic rd_dat(input string tag);          step(0, 1, 0, A_DATA, 8'h00, 0, 8'h00, tag); endtask
  task automatic push(input logic [7:0] b, input string tag); step(0, 0, 0, 8'h00, 8'h00, 1, b, tag); endtask
  task automatic expect_rd(input logic [7:0] v, input string tag);
    chk(rd_valid && rd_data == v, tag, "read value", rd_data, v);
  endtask

  initial begin
    @(negedge clk);
    do_reset("R1");
    chk(!irq && !err && !tx_valid && !rd_valid && rx_ready, "R1", "reset outputs",
        {irq, err, tx_valid, rd_valid, rx_ready}, 5'b00001);

    rd_ctrl("R4"); expect_rd(8'h04, "R4");
    wr_ctrl(8'h03, "R3"); rd_ctrl("R3"); expect_rd(8'h00, "R3");
    rd_ctrl("R3"); expect_rd(8'h04, "R3");
    wr_data(8'h41, "R5");
    chk(tx_valid && tx_data == 8'h41 && irq, "R5", "send", tx_data, 8'h41);
    wr_ctrl(8'h03, "R3"); rd_ctrl("R3"); expect_rd(8'h10, "R3");
    rd_ctrl("R4"); expect_rd(8'h04, "R4");
    wr_ctrl(8'h28, "R6"); chk(!irq && !err, "R6", "ack drop", irq, 0);
    wr_ctrl(8'h28, "R6"); chk(err, "R6", "spurious ack", err, 1);
    repeat (3) idle("R10");
    wr_data(8'h12, "R10"); chk(err, "R10", "err sticky", err, 1);

    do_reset("R1");
    push(8'hA1, "R7"); chk(irq, "R7", "rx irq", irq, 1);
    push(8'hA2, "R7"); push(8'hA3, "R7");
    rd_ctrl("R4"); expect_rd(8'h05, "R4");
    wr_ctrl(8'h03, "R3"); rd_ctrl("R3"); expect_rd(8'h20, "R3");
    wr_data(8'h55, "R3"); wr_ctrl(8'h03, "R3"); rd_ctrl("R3"); expect_rd(8'h10, "R3");
    wr_ctrl(8'h28, "R6"); chk(irq, "R6", "irq held by rx", irq, 1);
    rd_dat("R8"); expect_rd(8'hA1, "R8");
    rd_dat("R8"); expect_rd(8'hA2, "R8");
    rd_dat("R8"); expect_rd(8'hA3, "R8"); chk(!irq, "R8", "irq after drain", irq, 0);
    rd_dat("R9"); expect_rd(8'h00, "R9"); chk(err, "R9", "empty read err", err, 1);

    do_reset("R1");
    for (int i = 0; i < DEPTH + 2; i++) push(8'(i * 3 + 1), "R7");
    chk(!rx_ready, "R7", "full", rx_ready, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_dat("R8"); expect_rd(8'(i * 3 + 1), "R8");
    end
    chk(rx_ready && !irq, "R7", "drained", rx_ready, 1);

    do_reset("R1");
    step(0, 1, 0, A_DATA, 8'h00, 1, 8'h77, "R9");
    expect_rd(8'h00, "R9"); chk(err && irq, "R9", "race empty", {err, irq}, 2'b11);
    rd_dat("R9"); expect_rd(8'h77, "R9");

    do_reset("R1");
    push(8'h11, "R8");
    step(0, 1, 0, A_DATA, 8'h00, 1, 8'h22, "R8");
    expect_rd(8'h11, "R8"); chk(irq, "R8", "irq kept by arrival", irq, 1);
    rd_dat("R8"); expect_rd(8'h22, "R8"); chk(!irq, "R8", "irq clear", irq, 0);

    do_reset("R1");
    step(0, 0, 1, 8'h40, 8'h99, 0, 8'h00, "R2"); chk(!tx_valid && !irq, "R2", "stray write", irq, 0);
    step(0, 1, 0, 8'h40, 8'h00, 0, 8'h00, "R2"); expect_rd(8'h00, "R2");
    step(0, 1, 1, A_DATA, 8'h66, 0, 8'h00, "R2"); chk(!tx_valid, "R2", "rd+wr", tx_valid, 0);
    step(0, 0, 1, 8'h81, 8'h03, 0, 8'h00, "R2");
    rd_ctrl("R2"); expect_rd(8'h04, "R2");
    rd_ctrl("R11");

    do_reset("R1");
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0: step(0, 1, 0, A_CTRL, 8'h00, $urandom % 2, 8'($urandom), "R8");
        1: step(0, 1, 0, A_DATA, 8'h00, $urandom % 2, 8'($urandom), "R8");
        2: step(0, 0, 1, A_CTRL, ($urandom % 2) ? 8'h03 : 8'h28, $urandom % 2, 8'($urandom), "R3");
        3: step(0, 0, 1, A_DATA, 8'($urandom), $urandom % 2, 8'($urandom), "R5");
        default: step(0, 0, 0, 8'h00, 8'h00, $urandom % 2, 8'($urandom), "R7");
      endcase
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule